// File: doc/BRIEF.md
# Breaker Synchronism and Voltage Check

This block decides whether a circuit breaker may be closed. One side of the breaker is the polarizing side: three phase voltages, of which a setting picks one as the reference phasor. The other side is a single synchronizing voltage. The block forms the phasor difference between the two and tests it against a threshold in squared form, so no square root is needed. It also tests supplied magnitudes against undervoltage and overvoltage thresholds on both sides.

Closing permission, `sync_ok`, needs four qualifiers at once: the breaker is open (auxiliary contact low and residual overcurrent dropped out), the difference is small, the polarizing side is live and the synchronizing side is live. A delay timer in clock ticks must run out before `sync_ok` sets. Losing any qualifier clears both the timer and the output. Alongside this, a four-mode dead/live selector drives `vchk_ok`, which permits closing onto a dead bus or a dead line.

All qualifiers are registered one clock after the inputs, and both outputs are registered one clock after that. Phasor extraction, filtering and sequence-component calculation happen upstream.

Top module: `brk_sync_supervisor`

## Requirements
- R1: `pol_sel` picks the reference phasor. 0 selects phase A, 1 selects phase B and 2 selects phase C. Code 3 is invalid and selects phase A.
- R2: The difference element is true when (s_re-p_re)²+(s_im-p_im)² < diff_thr². The comparison is strict, and it is exact across the full signed 16-bit range of the phasor parts.
- R3: The breaker counts as open only when `brk_aux_closed` is 0 and `oc_pickup` is 0. Either input high blocks `sync_ok`.
- R4: Suppose all four qualifiers hold on inputs that are stable from before rising edge k, and `sync_ok` is low. With `delay_ticks` = D, `sync_ok` is still low after edge k+D and is high after edge k+1+D. It then stays high while the qualifiers hold.
- R5: Suppose a qualifier fails on the inputs sampled at edge j. Then `sync_ok` is low after edge j+1, and the timer restarts from zero. A later qualification waits the full delay again, even after a one-cycle dropout.
- R6: With `delay_ticks` = 0, `sync_ok` goes high after edge k+1, where k is the first edge at which all qualifiers are sampled true.
- R7: Each undervoltage element is true when its magnitude is strictly below its threshold. Each overvoltage (live) element is true when its magnitude is strictly above its threshold. The polarizing elements use `pol_mag` and the synchronizing elements use `syn_mag`. The polarizing-live element and the synchronizing-live element are both qualifiers for `sync_ok`.
- R8: `vchk_mode` sets `vchk_ok`, which changes after edge k+1 for inputs sampled at k. The modes are:
  - 0: `vchk_ok` is 0.
  - 1: synchronizing live AND polarizing dead.
  - 2: polarizing live AND synchronizing dead.
  - 3: the OR of modes 1 and 2.
- R9: `rst_n` is a synchronous reset, active low. A low `rst_n` at a rising edge clears `sync_ok`, `vchk_ok`, the timer and every qualifier register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| va_re | input | PW | Phase A phasor, real part (signed) |
| va_im | input | PW | Phase A phasor, imaginary part (signed) |
| vb_re | input | PW | Phase B phasor, real part (signed) |
| vb_im | input | PW | Phase B phasor, imaginary part (signed) |
| vc_re | input | PW | Phase C phasor, real part (signed) |
| vc_im | input | PW | Phase C phasor, imaginary part (signed) |
| vs_re | input | PW | Synchronizing phasor, real part (signed) |
| vs_im | input | PW | Synchronizing phasor, imaginary part (signed) |
| pol_mag | input | MW | Positive-sequence magnitude of the polarizing side |
| syn_mag | input | MW | Phase-to-neutral magnitude of the synchronizing input |
| brk_aux_closed | input | 1 | Breaker auxiliary contact, 1 = closed |
| oc_pickup | input | 1 | Residual overcurrent element, 1 = picked up |
| diff_thr | input | MW | Difference-voltage threshold |
| pol_uv_thr | input | MW | Polarizing undervoltage threshold |
| pol_ov_thr | input | MW | Polarizing live (overvoltage) threshold |
| syn_uv_thr | input | MW | Synchronizing undervoltage threshold |
| syn_ov_thr | input | MW | Synchronizing live (overvoltage) threshold |
| pol_sel | input | 2 | Reference phase select |
| vchk_mode | input | 2 | Dead/live voltage-check mode |
| delay_ticks | input | DLY_W | Qualification delay in clock ticks |
| sync_ok | output | 1 | Synchronism-check close permission |
| vchk_ok | output | 1 | Dead/live voltage-check condition |

## Verification
The bench targets several corner cases:
- The exact equality point of the squared comparison, with a 3-4-5 difference against thresholds of 5 and 6. A non-strict compare would wrongly permit closing here.
- Full-scale opposite-sign phasors, whose difference needs a 17-bit signed value. An adder one bit short would wrap and report a small difference.
- Each magnitude sitting exactly on its threshold. An inclusive comparison would flip the result.
- The invalid select code 3. A design that let it fall through would report no reference phasor.

On the timer side, the bench counts the exact edge at which `sync_ok` rises for nonzero and zero delays. It also injects a one-cycle overcurrent pickup partway through timing. A timer that paused instead of restarting would permit closing too early.

// File: rtl/brk_sync_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the breaker synchronism supervisor.
// Assumes: two-bit select and mode fields driven from static settings.
package brk_sync_pkg;

    // Reference phase select; code 3 is invalid and maps to phase A.
    typedef enum logic [1:0] {
        POL_A   = 2'd0,
        POL_B   = 2'd1,
        POL_C   = 2'd2,
        POL_BAD = 2'd3
    } pol_sel_e;

    // Dead/live voltage-check modes.
    typedef enum logic [1:0] {
        VCHK_OFF      = 2'd0,
        VCHK_LIVE_SYN = 2'd1,
        VCHK_LIVE_POL = 2'd2,
        VCHK_EITHER   = 2'd3
    } vchk_mode_e;

endpackage

// File: rtl/phasor_diff_cmp.sv
`timescale 1ns/1ps
// Module: phasor_diff_cmp
// Picks the reference phasor from three phases, subtracts it from the
// synchronizing phasor and registers whether the squared difference
// magnitude is strictly below the squared threshold.
// Assumes: two's-complement phasor parts; the internal widths are
// chosen so that no intermediate value can wrap.
module phasor_diff_cmp
    import brk_sync_pkg::*;
#(
    parameter int PW = 16,
    parameter int MW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           pol_sel,
    input  logic signed [PW-1:0] a_re,
    input  logic signed [PW-1:0] a_im,
    input  logic signed [PW-1:0] b_re,
    input  logic signed [PW-1:0] b_im,
    input  logic signed [PW-1:0] c_re,
    input  logic signed [PW-1:0] c_im,
    input  logic signed [PW-1:0] s_re,
    input  logic signed [PW-1:0] s_im,
    input  logic [MW-1:0]        thr,
    output logic                 diff_ok
);
    // A difference needs PW+1 bits; its square therefore fits 2*(PW+1) bits.
    localparam int SQW  = 2 * (PW + 1);
    localparam int SUMW = SQW + 1;
    localparam int TW   = 2 * MW;
    localparam int CW   = (SUMW > TW) ? SUMW : TW;

    logic signed [PW-1:0]  p_re, p_im;
    logic signed [SQW-1:0] d_re, d_im;
    logic signed [SQW-1:0] sq_re, sq_im;
    logic [SUMW-1:0]       mag2;
    logic [TW-1:0]         thr2;

    // Reference phasor select; invalid code falls back to phase A.
    always_comb begin
        case (pol_sel_e'(pol_sel))
            POL_B:   begin p_re = b_re; p_im = b_im; end
            POL_C:   begin p_re = c_re; p_im = c_im; end
            default: begin p_re = a_re; p_im = a_im; end
        endcase
    end

    // Sign-extended difference, squares and sum of squares.
    always_comb begin
        d_re  = SQW'(s_re) - SQW'(p_re);
        d_im  = SQW'(s_im) - SQW'(p_im);
        sq_re = d_re * d_re;
        sq_im = d_im * d_im;
        mag2  = SUMW'($unsigned(sq_re)) + SUMW'($unsigned(sq_im));
        thr2  = TW'(thr) * TW'(thr);
    end

    // Register the strict squared-magnitude comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) diff_ok <= 1'b0;
        else        diff_ok <= CW'(mag2) < CW'(thr2);
    end

endmodule

// File: rtl/volt_level_det.sv
`timescale 1ns/1ps
// Module: volt_level_det
// Registered single-threshold magnitude detector. With OVER = 1 it flags
// a magnitude strictly above the threshold, otherwise strictly below.
// Assumes: unsigned magnitude and threshold of equal width.
module volt_level_det #(
    parameter int MW   = 16,
    parameter bit OVER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mag,
    input  logic [MW-1:0] thr,
    output logic          hit
);
    logic hit_d;

    generate
        if (OVER) begin : g_over
            // Strict overvoltage (live) comparison.
            always_comb hit_d = mag > thr;
        end else begin : g_under
            // Strict undervoltage (dead) comparison.
            always_comb hit_d = mag < thr;
        end
    endgenerate

    // Register the comparison result.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= hit_d;
    end

endmodule

// File: rtl/vchk_logic.sv
`timescale 1ns/1ps
// Module: vchk_logic
// Combines the registered dead/live flags of both sides according to the
// mode setting and registers the voltage-check condition.
// Assumes: the mode is a static setting sampled together with the flags.
module vchk_logic
    import brk_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       pol_live,
    input  logic       pol_dead,
    input  logic       syn_live,
    input  logic       syn_dead,
    output logic       vchk_ok
);
    logic live_syn_dead_pol, live_pol_dead_syn, vchk_d;

    // Form the two dead/live terms and pick per mode.
    always_comb begin
        live_syn_dead_pol = syn_live & pol_dead;
        live_pol_dead_syn = pol_live & syn_dead;
        case (vchk_mode_e'(mode))
            VCHK_LIVE_SYN: vchk_d = live_syn_dead_pol;
            VCHK_LIVE_POL: vchk_d = live_pol_dead_syn;
            VCHK_EITHER:   vchk_d = live_syn_dead_pol | live_pol_dead_syn;
            default:       vchk_d = 1'b0;
        endcase
    end

    // Register the voltage-check condition.
    always_ff @(posedge clk) begin
        if (!rst_n) vchk_ok <= 1'b0;
        else        vchk_ok <= vchk_d;
    end

endmodule

// File: rtl/sync_qual_timer.sv
`timescale 1ns/1ps
// Module: sync_qual_timer
// Qualification timer. It counts while the combined qualifier holds and
// sets the output once the count reaches the delay. Losing the qualifier
// clears the count and the output on the next clock.
// Assumes: the qualifier comes from registered flags; the count never
// passes the delay, so it cannot overflow.
module sync_qual_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_all,
    input  logic [DLY_W-1:0] delay_ticks,
    output logic [DLY_W-1:0] tmr_cnt,
    output logic             sync_ok
);
    // Count, expire and latch; any qualifier loss restarts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_cnt <= '0;
            sync_ok <= 1'b0;
        end else if (!qual_all) begin
            tmr_cnt <= '0;
            sync_ok <= 1'b0;
        end else if (!sync_ok) begin
            if (tmr_cnt >= delay_ticks) sync_ok <= 1'b1;
            else                        tmr_cnt <= tmr_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/brk_sync_supervisor.sv
`timescale 1ns/1ps
// Module: brk_sync_supervisor (top)
// Breaker close supervision. Stage 1 registers the qualifiers: the
// difference element, the four level elements and breaker-open. Stage 2
// registers the timed sync-check permission and the dead/live condition.
// Assumes: magnitudes are computed upstream; settings are quasi-static.
module brk_sync_supervisor #(
    parameter int PW    = 16,
    parameter int MW    = 16,
    parameter int DLY_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [PW-1:0] va_re,
    input  logic signed [PW-1:0] va_im,
    input  logic signed [PW-1:0] vb_re,
    input  logic signed [PW-1:0] vb_im,
    input  logic signed [PW-1:0] vc_re,
    input  logic signed [PW-1:0] vc_im,
    input  logic signed [PW-1:0] vs_re,
    input  logic signed [PW-1:0] vs_im,
    input  logic [MW-1:0]        pol_mag,
    input  logic [MW-1:0]        syn_mag,
    input  logic                 brk_aux_closed,
    input  logic                 oc_pickup,
    input  logic [MW-1:0]        diff_thr,
    input  logic [MW-1:0]        pol_uv_thr,
    input  logic [MW-1:0]        pol_ov_thr,
    input  logic [MW-1:0]        syn_uv_thr,
    input  logic [MW-1:0]        syn_ov_thr,
    input  logic [1:0]           pol_sel,
    input  logic [1:0]           vchk_mode,
    input  logic [DLY_W-1:0]     delay_ticks,
    output logic                 sync_ok,
    output logic                 vchk_ok
);
    localparam int NLVL = 4;  // pol live, pol dead, syn live, syn dead

    logic             diff_ok, brk_open_q, qual_all;
    logic [NLVL-1:0]  lvl_hit;
    logic [DLY_W-1:0] tmr_cnt;
    logic [MW-1:0]    lvl_mag [NLVL];
    logic [MW-1:0]    lvl_thr [NLVL];

    // Route magnitudes and thresholds to the level detectors.
    always_comb begin
        lvl_mag[0] = pol_mag; lvl_thr[0] = pol_ov_thr;
        lvl_mag[1] = pol_mag; lvl_thr[1] = pol_uv_thr;
        lvl_mag[2] = syn_mag; lvl_thr[2] = syn_ov_thr;
        lvl_mag[3] = syn_mag; lvl_thr[3] = syn_uv_thr;
    end

    phasor_diff_cmp #(.PW(PW), .MW(MW)) u_diff (
        .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel),
        .a_re(va_re), .a_im(va_im), .b_re(vb_re), .b_im(vb_im),
        .c_re(vc_re), .c_im(vc_im), .s_re(vs_re), .s_im(vs_im),
        .thr(diff_thr), .diff_ok(diff_ok)
    );

    // Even indices are live (over) detectors, odd are dead (under).
    generate
        for (genvar i = 0; i < NLVL; i++) begin : g_lvl
            volt_level_det #(.MW(MW), .OVER((i % 2) == 0)) u_lvl (
                .clk(clk), .rst_n(rst_n), .mag(lvl_mag[i]),
                .thr(lvl_thr[i]), .hit(lvl_hit[i])
            );
        end
    endgenerate

    // Register the breaker-open qualifier in step with the other flags.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_open_q <= 1'b0;
        else        brk_open_q <= !brk_aux_closed && !oc_pickup;
    end

    // All four closing qualifiers at once.
    always_comb qual_all = brk_open_q & diff_ok & lvl_hit[0] & lvl_hit[2];

    sync_qual_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .qual_all(qual_all),
        .delay_ticks(delay_ticks), .tmr_cnt(tmr_cnt), .sync_ok(sync_ok)
    );

    vchk_logic u_vchk (
        .clk(clk), .rst_n(rst_n), .mode(vchk_mode),
        .pol_live(lvl_hit[0]), .pol_dead(lvl_hit[1]),
        .syn_live(lvl_hit[2]), .syn_dead(lvl_hit[3]),
        .vchk_ok(vchk_ok)
    );

endmodule

// File: rtl/brk_sync_chk.sv
`timescale 1ns/1ps
// Module: brk_sync_chk
// Assertion checker bound into brk_sync_supervisor. It watches the
// combined qualifier, the timer count and both outputs.
// Assumes: the synchronous reset is active low.
module brk_sync_chk #(
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk_aux_closed,
    input logic [1:0]       vchk_mode,
    input logic [DLY_W-1:0] delay_ticks,
    input logic             qual_all,
    input logic [DLY_W-1:0] tmr_cnt,
    input logic             sync_ok,
    input logic             vchk_ok
);
    // R5
    drop_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_all |=> !sync_ok);

    // R5
    drop_clears_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_all |=> (tmr_cnt == '0));

    // R4
    hold_while_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && qual_all) |=> sync_ok);

    // R4
    rise_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(qual_all));

    // R6
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_all && delay_ticks == '0) |=> sync_ok);

    // R3
    aux_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_aux_closed |=> ##1 !sync_ok);

    // R8
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vchk_mode == 2'd0) |=> !vchk_ok);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!sync_ok && !vchk_ok && tmr_cnt == '0));

endmodule

bind brk_sync_supervisor brk_sync_chk #(.DLY_W(DLY_W)) u_brk_sync_chk (
    .clk(clk), .rst_n(rst_n), .brk_aux_closed(brk_aux_closed),
    .vchk_mode(vchk_mode), .delay_ticks(delay_ticks), .qual_all(qual_all),
    .tmr_cnt(tmr_cnt), .sync_ok(sync_ok), .vchk_ok(vchk_ok)
);

// File: tb/test_brk_sync_supervisor.sv
`timescale 1ns/1ps
module test_brk_sync_supervisor;
    localparam int PW = 16, MW = 16, DLY_W = 16;
    localparam int D  = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic signed [PW-1:0] va_re, va_im, vb_re, vb_im, vc_re, vc_im, vs_re, vs_im;
    logic [MW-1:0] pol_mag, syn_mag, diff_thr;
    logic [MW-1:0] pol_uv_thr, pol_ov_thr, syn_uv_thr, syn_ov_thr;
    logic brk_aux_closed, oc_pickup;
    logic [1:0] pol_sel, vchk_mode;
    logic [DLY_W-1:0] delay_ticks;
    logic sync_ok, vchk_ok;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    brk_sync_supervisor #(.PW(PW), .MW(MW), .DLY_W(DLY_W)) i_brk_sync_supervisor (
        .clk(clk), .rst_n(rst_n),
        .va_re(va_re), .va_im(va_im), .vb_re(vb_re), .vb_im(vb_im),
        .vc_re(vc_re), .vc_im(vc_im), .vs_re(vs_re), .vs_im(vs_im),
        .pol_mag(pol_mag), .syn_mag(syn_mag),
        .brk_aux_closed(brk_aux_closed), .oc_pickup(oc_pickup),
        .diff_thr(diff_thr), .pol_uv_thr(pol_uv_thr), .pol_ov_thr(pol_ov_thr),
        .syn_uv_thr(syn_uv_thr), .syn_ov_thr(syn_ov_thr),
        .pol_sel(pol_sel), .vchk_mode(vchk_mode), .delay_ticks(delay_ticks),
        .sync_ok(sync_ok), .vchk_ok(vchk_ok)
    );

    typedef struct packed {
        logic [1:0]           sel;
        logic signed [15:0]   a, b, c, s_re, s_im;
        logic [15:0]          thr, pmag, smag;
        logic [1:0]           mode;
        logic                 exp_sync, exp_vchk;
    } vec_t;

    // Level thresholds fixed at dead < 20, live > 80; breaker open; delay 0.
    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{2'd0,  16'sd1000, 16'sd0,   16'sd0,    16'sd1000,  16'sd0,    16'd10,    16'd100, 16'd100, 2'd0, 1'b1, 1'b0},
        '{2'd1,  16'sd1000, 16'sd500, 16'sd0,    16'sd500,   16'sd0,    16'd10,    16'd100, 16'd100, 2'd1, 1'b1, 1'b0},
        '{2'd2,  16'sd1000, 16'sd0,  -16'sd300, -16'sd300,   16'sd0,    16'd10,    16'd100, 16'd100, 2'd3, 1'b1, 1'b0},
        '{2'd3,  16'sd200,  16'sd0,   16'sd0,    16'sd200,   16'sd0,    16'd10,    16'd100, 16'd100, 2'd0, 1'b1, 1'b0},
        '{2'd1,  16'sd200,  16'sd0,   16'sd0,    16'sd200,   16'sd0,    16'd10,    16'd100, 16'd100, 2'd0, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd3,     16'sd4,    16'd5,     16'd100, 16'd100, 2'd0, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd3,     16'sd4,    16'd6,     16'd100, 16'd100, 2'd0, 1'b1, 1'b0},
        '{2'd0, -16'sd32768,16'sd0,   16'sd0,    16'sd32767, 16'sd0,    16'd65535, 16'd100, 16'd100, 2'd0, 1'b0, 1'b0},
        '{2'd0, -16'sd32767,16'sd0,   16'sd0,    16'sd32767, 16'sd0,    16'd65535, 16'd100, 16'd100, 2'd0, 1'b1, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd10,  16'd100, 2'd1, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd100, 16'd10,  2'd2, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd10,  16'd100, 2'd3, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd100, 16'd10,  2'd3, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd10,  16'd100, 2'd2, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd10,  16'd100, 2'd0, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd80,  16'd100, 2'd1, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd81,  16'd100, 2'd1, 1'b1, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd20,  16'd100, 2'd1, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd19,  16'd100, 2'd1, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd100, 16'd20,  2'd2, 1'b0, 1'b0},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd100, 16'd19,  2'd2, 1'b0, 1'b1},
        '{2'd0,  16'sd0,    16'sd0,   16'sd0,    16'sd0,     16'sd0,    16'd10,    16'd19,  16'd80,  2'd1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_vec(input vec_t v);
        pol_sel = v.sel;
        va_re = v.a; vb_re = v.b; vc_re = v.c;
        va_im = '0;  vb_im = '0;  vc_im = '0;
        vs_re = v.s_re; vs_im = v.s_im;
        diff_thr = v.thr; pol_mag = v.pmag; syn_mag = v.smag;
        vchk_mode = v.mode;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        pol_uv_thr = 16'd20; pol_ov_thr = 16'd80;
        syn_uv_thr = 16'd20; syn_ov_thr = 16'd80;
        brk_aux_closed = 1'b0; oc_pickup = 1'b0;
        delay_ticks = '0;
        // Inputs that would give vchk_ok = 1 in mode 1, held through reset.
        load_vec(VT[9]);
        edges(4);
        check("R9 reset sync_ok", sync_ok, 1'b0);
        check("R9 reset vchk_ok", vchk_ok, 1'b0);
        rst_n = 1'b1;
        edges(1);
        check("R8 vchk latency edge k", vchk_ok, 1'b0);
        edges(1);
        check("R8 vchk after edge k+1", vchk_ok, 1'b1);

        // Vector table, zero delay: R1 R2 R7 R8 via sync_ok and vchk_ok.
        for (int i = 0; i < NV; i++) begin
            load_vec(VT[i]);
            edges(2);
            check($sformatf("R1/R2/R7 vec%0d sync_ok", i), sync_ok, VT[i].exp_sync);
            check($sformatf("R7/R8 vec%0d vchk_ok", i), vchk_ok, VT[i].exp_vchk);
        end

        // R3: closed auxiliary contact blocks; then R4 timing with delay D.
        load_vec(VT[0]);
        delay_ticks = DLY_W'(D);
        brk_aux_closed = 1'b1;
        edges(3);
        check("R3 aux closed blocks", sync_ok, 1'b0);
        brk_aux_closed = 1'b0;
        for (int n = 1; n <= D + 3; n++) begin
            edges(1);
            check($sformatf("R4 delay edge %0d", n), sync_ok, n >= D + 2);
        end

        // R5: drop latency on aux close.
        brk_aux_closed = 1'b1;
        edges(1);
        check("R5 drop after one edge", sync_ok, 1'b1);
        edges(1);
        check("R5 drop after two edges", sync_ok, 1'b0);

        // R5: requalify waits the full delay again.
        brk_aux_closed = 1'b0;
        edges(D + 1);
        check("R5 requalify early", sync_ok, 1'b0);
        edges(1);
        check("R5 requalify on time", sync_ok, 1'b1);

        // R3: overcurrent pickup blocks.
        oc_pickup = 1'b1;
        edges(2);
        check("R3 overcurrent blocks", sync_ok, 1'b0);

        // R5: one-cycle dropout mid-timing restarts the timer.
        oc_pickup = 1'b0;
        edges(3);
        oc_pickup = 1'b1;
        edges(1);
        oc_pickup = 1'b0;
        edges(D + 1);
        check("R5 glitch restart early", sync_ok, 1'b0);
        edges(1);
        check("R5 glitch restart on time", sync_ok, 1'b1);

        // R6: zero delay from a disqualified state.
        brk_aux_closed = 1'b1;
        delay_ticks = '0;
        edges(3);
        brk_aux_closed = 1'b0;
        edges(1);
        check("R6 zero delay edge k", sync_ok, 1'b0);
        edges(1);
        check("R6 zero delay edge k+1", sync_ok, 1'b1);

        // R9: reset while sync_ok is set.
        rst_n = 1'b0;
        edges(1);
        check("R9 mid reset sync_ok", sync_ok, 1'b0);
        check("R9 mid reset vchk_ok", vchk_ok, 1'b0);
        rst_n = 1'b1;
        edges(2);
        check("R6 after reset release", sync_ok, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule